// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a snooping bus. It follows a write-back, write-invalidate discipline with four line states: Modified (sole dirty copy), Exclusive (sole clean copy), Shared (one of possibly several clean copies) and Invalid. It stores the tag and coherence state of every set. It does not hold line data, so data movement appears only as request and flush strobes.

The processor side presents reads, writes and explicit replacements one at a time. The controller completes hits locally. For everything else it raises a bus request and waits for an external grant. The wired-OR shared line is sampled in the grant cycle of a read fill, and it decides whether the line fills Exclusive or Shared.

The snoop side sees every foreign bus transaction. In the same cycle the controller drives its contribution to the shared line and a flush strobe when it owns dirty data. At the next edge it demotes or invalidates its copy. Addresses are line addresses: the low bits index the set and the high bits form the tag.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and neither `bus_req_valid` nor `cpu_done` is asserted.
- R2: `snp_shared_out` is high exactly when a snooped read (`snp_cmd`=0) finds the address in any valid state. It is low for misses and for other commands.
- R3: Processor operations are encoded on `cpu_op` as read=0, write=1, replace=2. Bus commands are encoded as read=0, read-exclusive=1, upgrade=2, write-back=3. A read hit completes with no bus request. A read miss issues a read and fills Shared if `bus_shared_in` was high in the grant cycle, or Exclusive if it was low.
- R4: A write to an Exclusive or Modified line completes with no bus request and leaves the line Modified.
- R5: A write to a Shared line issues an upgrade, and a write miss issues a read-exclusive. Both leave the line Modified.
- R6: A snooped read demotes Exclusive to Shared. It demotes Modified to Shared and asserts `snp_flush` in that cycle.
- R7: A snooped read-exclusive or upgrade invalidates a matching line and asserts `snp_flush` if the line was Modified.
- R8: Replacing a Modified line issues a write-back and then invalidates the line. Replacing an Exclusive or Shared line invalidates it with no bus request. Replacing an absent address does nothing.
- R9: A miss whose set holds a different Modified line first writes that victim back and then issues the fill. A clean victim is overwritten with no write-back.
- R10: If a pending upgrade's line is invalidated by a snoop before the grant, the request is reissued as a read-exclusive.
- R11: If a pending victim write-back's line stops being Modified because of a snoop, the write-back is dropped and the fill follows.
- R12: A snooped write-back (`snp_cmd`=3) changes no state and drives neither `snp_shared_out` nor `snp_flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor operation present |
| cpu_op | input | 2 | Operation: 0 read, 1 write, 2 replace |
| cpu_addr | input | 12 | Line address of the operation |
| cpu_ready | output | 1 | Operation accepted this cycle when valid |
| cpu_done | output | 1 | One-cycle pulse when the accepted operation completes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | Requested command: 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_req_addr | output | 12 | Line address of the requested transaction |
| bus_grant | input | 1 | The request is placed on the bus this cycle |
| bus_shared_in | input | 1 | Resolved wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Foreign transaction being snooped |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | 12 | Snooped line address |
| snp_shared_out | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The bench targets the races between a pending request and an intervening snoop. An upgrade whose line was invalidated while it waited must turn into a read-exclusive. A design that kept the upgrade would end Modified without ever fetching the data. A victim write-back whose line a snoop had demoted must vanish, or stale data would be written over memory a second time. Further cases are fill-state selection from the shared line, silent drops of clean victims and clean replacements, and a snooped write-back that must leave state untouched. A wrong design would show these as extra or missing bus requests, or as a wrong shared or flush response on the next probe.

// File: rtl/mesi_ctl_pkg.sv
package mesi_ctl_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD   = 2'd0,
        BC_RDX  = 2'd1,
        BC_UPGR = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_REPL  = 2'd2,
        OP_NONE  = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WB   = 2'd1,
        PH_FILL = 2'd2
    } phase_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_ctl_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_e         a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_e         b_st,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_e         w_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [TAG_W-1:0] tag_d [SETS];
    line_st_e         st_q  [SETS];
    line_st_e         st_d  [SETS];

    always_comb begin
        tag_d = tag_q;
        st_d  = st_q;
        if (we) begin
            tag_d[w_idx] = w_tag;
            st_d[w_idx]  = w_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_I;
            end
        end else begin
            tag_q <= tag_d;
            st_q  <= st_d;
        end
    end

    assign a_tag = tag_q[a_idx];
    assign a_st  = st_q[a_idx];
    assign b_tag = tag_q[b_idx];
    assign b_st  = st_q[b_idx];

    // R1: a set just written Invalid reads back Invalid on the next cycle
    a_r1_inval_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_st == LS_I && a_idx == w_idx) |=> (a_idx != $past(w_idx) || a_st == LS_I || $past(we) == 1'b0 || $rose(we)));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_ctl_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             hit,
    output logic             shared,
    output logic             flush,
    output logic             upd,
    output line_st_e         nxt_st
);
    always_comb begin
        hit    = snp_valid && (line_st != LS_I) && (line_tag == snp_tag);
        shared = hit && (snp_cmd == BC_RD);
        flush  = hit && (line_st == LS_M) && (snp_cmd != BC_WB);
        upd    = 1'b0;
        nxt_st = line_st;
        unique case (snp_cmd)
            BC_RD: begin
                if (hit && (line_st == LS_E || line_st == LS_M)) begin
                    upd    = 1'b1;
                    nxt_st = LS_S;
                end
            end
            BC_RDX, BC_UPGR: begin
                if (hit) begin
                    upd    = 1'b1;
                    nxt_st = LS_I;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_ctl_pkg::*;
#(
    parameter int LINE_AW = 12,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic [1:0]         cpu_op,
    input  logic [LINE_AW-1:0] cpu_addr,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic               bus_req_valid,
    output logic [1:0]         bus_req_cmd,
    output logic [LINE_AW-1:0] bus_req_addr,
    input  logic               bus_grant,
    input  logic               bus_shared_in,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [LINE_AW-1:0] snp_addr,
    output logic               snp_shared_out,
    output logic               snp_flush
);
    localparam int TAG_W = LINE_AW - IDX_W;

    typedef struct packed {
        phase_e           ph;
        cpu_op_e          op;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [IDX_W-1:0] cpu_idx, snp_idx, a_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, a_tag, b_tag;
    line_st_e         a_st, b_st;
    cpu_op_e          op_in;
    bus_cmd_e         snp_cmd_e;

    logic             snp_hit, snp_upd;
    line_st_e         snp_nxt;

    logic             fsm_we;
    logic [TAG_W-1:0] fsm_tag;
    line_st_e         fsm_st;

    logic             arr_we;
    logic [IDX_W-1:0] arr_idx;
    logic [TAG_W-1:0] arr_tag;
    line_st_e         arr_st;

    logic             req_valid;
    bus_cmd_e         req_cmd;
    logic [LINE_AW-1:0] req_addr;

    logic             cpu_hit, own_hit, accept;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[LINE_AW-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[LINE_AW-1:IDX_W];
    assign op_in     = cpu_op_e'(cpu_op);
    assign snp_cmd_e = bus_cmd_e'(snp_cmd);
    assign a_idx     = (ctl_q.ph == PH_IDLE) ? cpu_idx : ctl_q.idx;

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .a_idx (a_idx),
        .a_tag (a_tag),
        .a_st  (a_st),
        .b_idx (snp_idx),
        .b_tag (b_tag),
        .b_st  (b_st),
        .we    (arr_we),
        .w_idx (arr_idx),
        .w_tag (arr_tag),
        .w_st  (arr_st)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd_e),
        .snp_tag   (snp_tag),
        .line_tag  (b_tag),
        .line_st   (b_st),
        .hit       (snp_hit),
        .shared    (snp_shared_out),
        .flush     (snp_flush),
        .upd       (snp_upd),
        .nxt_st    (snp_nxt)
    );

    assign cpu_hit = (a_st != LS_I) && (a_tag == cpu_tag);
    assign own_hit = (a_st != LS_I) && (a_tag == ctl_q.tag);
    assign accept  = (ctl_q.ph == PH_IDLE) && cpu_valid && !snp_valid;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        fsm_we    = 1'b0;
        fsm_tag   = a_tag;
        fsm_st    = a_st;
        req_valid = 1'b0;
        req_cmd   = BC_RD;
        req_addr  = {ctl_q.tag, ctl_q.idx};

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    ctl_d.op  = op_in;
                    ctl_d.tag = cpu_tag;
                    ctl_d.idx = cpu_idx;
                    unique case (op_in)
                        OP_READ: begin
                            if (cpu_hit)            ctl_d.done = 1'b1;
                            else if (a_st == LS_M)  ctl_d.ph   = PH_WB;
                            else                    ctl_d.ph   = PH_FILL;
                        end
                        OP_WRITE: begin
                            if (cpu_hit && (a_st == LS_E || a_st == LS_M)) begin
                                fsm_we     = 1'b1;
                                fsm_st     = LS_M;
                                ctl_d.done = 1'b1;
                            end else if (cpu_hit) begin
                                ctl_d.ph = PH_FILL;
                            end else if (a_st == LS_M) begin
                                ctl_d.ph = PH_WB;
                            end else begin
                                ctl_d.ph = PH_FILL;
                            end
                        end
                        OP_REPL: begin
                            if (cpu_hit && a_st == LS_M) begin
                                ctl_d.ph = PH_WB;
                            end else if (cpu_hit) begin
                                fsm_we     = 1'b1;
                                fsm_st     = LS_I;
                                ctl_d.done = 1'b1;
                            end else begin
                                ctl_d.done = 1'b1;
                            end
                        end
                        default: ctl_d.done = 1'b1;
                    endcase
                end
            end

            PH_WB: begin
                if (a_st == LS_M) begin
                    req_valid = 1'b1;
                    req_cmd   = BC_WB;
                    req_addr  = {a_tag, ctl_q.idx};
                    if (bus_grant) begin
                        fsm_we = 1'b1;
                        fsm_st = LS_I;
                        if (ctl_q.op == OP_REPL) begin
                            ctl_d.ph   = PH_IDLE;
                            ctl_d.done = 1'b1;
                        end else begin
                            ctl_d.ph = PH_FILL;
                        end
                    end
                end else if (!snp_valid) begin
                    // victim lost its dirty data to a snoop: no write-back
                    if (ctl_q.op == OP_REPL) begin
                        fsm_we     = own_hit;
                        fsm_st     = LS_I;
                        ctl_d.ph   = PH_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.ph = PH_FILL;
                    end
                end
            end

            PH_FILL: begin
                req_valid = 1'b1;
                if (ctl_q.op == OP_READ)               req_cmd = BC_RD;
                else if (own_hit && a_st == LS_S)      req_cmd = BC_UPGR;
                else                                   req_cmd = BC_RDX;
                if (bus_grant) begin
                    fsm_we     = 1'b1;
                    fsm_tag    = ctl_q.tag;
                    fsm_st     = (ctl_q.op == OP_READ) ? (bus_shared_in ? LS_S : LS_E) : LS_M;
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                end
            end

            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, op: OP_NONE, tag: '0, idx: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        arr_we  = fsm_we || snp_upd;
        arr_idx = fsm_we ? a_idx   : snp_idx;
        arr_tag = fsm_we ? fsm_tag : b_tag;
        arr_st  = fsm_we ? fsm_st  : snp_nxt;
    end

    assign cpu_ready     = (ctl_q.ph == PH_IDLE) && !snp_valid;
    assign cpu_done      = ctl_q.done;
    assign bus_req_valid = req_valid;
    assign bus_req_cmd   = req_cmd;
    assign bus_req_addr  = req_addr;

    // R4: a write accepted on an Exclusive or Modified line finishes at once, off the bus
    a_r4_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_in == OP_WRITE && cpu_hit && (a_st == LS_E || a_st == LS_M))
        |=> (cpu_done && !bus_req_valid));

    // R3: a granted read fill completes in the following cycle
    a_r3_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && bus_req_cmd == BC_RD) |=> cpu_done);

    // R2: the shared line is only driven for snooped reads
    a_r2_shared_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_out |-> (snp_valid && snp_cmd_e == BC_RD));

    // R7: after an invalidating snoop hit, a repeat read snoop of that line misses
    a_r7_inval_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd_e == BC_RD && snp_addr == $past(snp_addr) && !$past(fsm_we)
         && $past(snp_valid && snp_hit && (snp_cmd_e == BC_RDX || snp_cmd_e == BC_UPGR)))
        |-> !snp_shared_out);

    // R6: after a read snoop hit, the line is no longer dirty
    a_r6_demote_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_addr == $past(snp_addr) && !$past(fsm_we)
         && $past(snp_valid && snp_hit && snp_cmd_e == BC_RD))
        |-> !snp_flush);

    // R5: an upgrade is only ever requested on behalf of a write
    a_r5_upgrade_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_UPGR) |-> (ctl_q.op == OP_WRITE));

    // R11: the state array never sees the request side and the snoop side write together
    a_r11_one_array_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsm_we && snp_upd));

    // R10: a granted cycle carries no foreign snoop (one transaction per bus cycle)
    a_r10_grant_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && bus_req_valid) |-> !snp_valid);

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [1:0]  cpu_op = 2'd0;
    logic [11:0] cpu_addr = '0;
    logic        cpu_ready, cpu_done;
    logic        bus_req_valid;
    logic [1:0]  bus_req_cmd;
    logic [11:0] bus_req_addr;
    logic        bus_grant = 1'b0;
    logic        bus_shared_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = 2'd0;
    logic [11:0] snp_addr = '0;
    logic        snp_shared_out, snp_flush;

    always #4 clk = ~clk;

    mesi_snoop_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared_out(snp_shared_out), .snp_flush(snp_flush)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_RP = 3'd2;
    localparam logic [2:0] K_SRD = 3'd4, K_SRX = 3'd5, K_SUP = 3'd6, K_SWB = 3'd7;
    localparam logic [2:0] X_NO = 3'b000, X_RD = 3'b100, X_RDX = 3'b101, X_UPG = 3'b110, X_WB = 3'b111;
    localparam logic [11:0] A = 12'h012, B = 12'h022, C = 12'h035, D = 12'h077, E = 12'h087;

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  kind;
        logic [11:0] addr;
        logic        shin;
        logic [2:0]  e0;
        logic [11:0] e0a;
        logic [2:0]  e1;
        logic        esh;
        logic        efl;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VT [NV] = '{
        '{4'd3,  K_RD,  A, 1'b0, X_RD,  A, X_NO, 1'b0, 1'b0}, // R3 miss fills E
        '{4'd4,  K_WR,  A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R4 E->M silent
        '{4'd6,  K_SRD, A, 1'b0, X_NO,  A, X_NO, 1'b1, 1'b1}, // R6 M->S with flush
        '{4'd5,  K_WR,  A, 1'b0, X_UPG, A, X_NO, 1'b0, 1'b0}, // R5 S write upgrades
        '{4'd7,  K_SRX, A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b1}, // R7 M invalidated, flushed
        '{4'd3,  K_RD,  A, 1'b1, X_RD,  A, X_NO, 1'b0, 1'b0}, // R3 miss fills S
        '{4'd2,  K_SRD, A, 1'b0, X_NO,  A, X_NO, 1'b1, 1'b0}, // R2 shared from S
        '{4'd5,  K_WR,  A, 1'b0, X_UPG, A, X_NO, 1'b0, 1'b0}, // R5
        '{4'd9,  K_RD,  B, 1'b0, X_WB,  A, X_RD, 1'b0, 1'b0}, // R9 dirty victim written back
        '{4'd9,  K_SRD, A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R9 victim gone
        '{4'd4,  K_WR,  B, 1'b0, X_NO,  B, X_NO, 1'b0, 1'b0}, // R4
        '{4'd8,  K_RP,  B, 1'b0, X_WB,  B, X_NO, 1'b0, 1'b0}, // R8 dirty replace
        '{4'd8,  K_SRD, B, 1'b0, X_NO,  B, X_NO, 1'b0, 1'b0}, // R8
        '{4'd5,  K_WR,  C, 1'b0, X_RDX, C, X_NO, 1'b0, 1'b0}, // R5 write miss
        '{4'd7,  K_SUP, C, 1'b0, X_NO,  C, X_NO, 1'b0, 1'b1}, // R7 upgrade snoop
        '{4'd3,  K_RD,  C, 1'b0, X_RD,  C, X_NO, 1'b0, 1'b0}, // R3
        '{4'd6,  K_SRD, C, 1'b0, X_NO,  C, X_NO, 1'b1, 1'b0}, // R6 E->S no flush
        '{4'd8,  K_RP,  C, 1'b0, X_NO,  C, X_NO, 1'b0, 1'b0}, // R8 clean replace
        '{4'd8,  K_SRD, C, 1'b0, X_NO,  C, X_NO, 1'b0, 1'b0}, // R8
        '{4'd3,  K_RD,  A, 1'b0, X_RD,  A, X_NO, 1'b0, 1'b0}, // R3
        '{4'd12, K_SWB, A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R12 write-back snoop
        '{4'd12, K_WR,  A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R12 still E
        '{4'd7,  K_SUP, A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b1}, // R7
        '{4'd3,  K_RD,  A, 1'b1, X_RD,  A, X_NO, 1'b0, 1'b0}, // R3
        '{4'd9,  K_RD,  B, 1'b0, X_RD,  B, X_NO, 1'b0, 1'b0}, // R9 clean victim dropped
        '{4'd9,  K_SRD, A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R9
        '{4'd3,  K_RD,  B, 1'b0, X_NO,  B, X_NO, 1'b0, 1'b0}, // R3 read hit
        '{4'd8,  K_RP,  A, 1'b0, X_NO,  A, X_NO, 1'b0, 1'b0}, // R8 absent replace
        '{4'd2,  K_SRD, B, 1'b0, X_NO,  B, X_NO, 1'b1, 1'b0}  // R2
    };

    task automatic chk(input logic ok, input int rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    task automatic cpu_run(input logic [1:0] op, input logic [11:0] addr, input logic shin,
                           output logic [2:0] g0, output logic [11:0] g0a,
                           output logic [2:0] g1, output logic [11:0] g1a, output int n);
        int t;
        g0 = X_NO; g1 = X_NO; g0a = '0; g1a = '0; n = 0;
        @(negedge clk);
        t = 0;
        while (!cpu_ready && t < 50) begin @(negedge clk); t++; end
        cpu_valid = 1'b1; cpu_op = op; cpu_addr = addr;
        @(negedge clk);
        cpu_valid = 1'b0;
        t = 0;
        while (!cpu_done && t < 50) begin
            if (bus_req_valid) begin
                if (n == 0) begin g0 = {1'b1, bus_req_cmd}; g0a = bus_req_addr; end
                else        begin g1 = {1'b1, bus_req_cmd}; g1a = bus_req_addr; end
                n++;
                bus_grant = 1'b1; bus_shared_in = shin;
                @(negedge clk);
                bus_grant = 1'b0; bus_shared_in = 1'b0;
            end else begin
                @(negedge clk);
            end
            t++;
        end
        if (!cpu_done) n = 99;
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [11:0] addr,
                         output logic sh, output logic fl);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
        #1;
        sh = snp_shared_out; fl = snp_flush;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        logic [2:0]  g0, g1;
        logic [11:0] g0a, g1a;
        int          n;
        logic        sh, fl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(cpu_ready == 1'b1, 1, "ready after reset", 16'(cpu_ready), 16'd1);
        chk(bus_req_valid == 1'b0, 1, "no request after reset", 16'(bus_req_valid), 16'd0);
        chk(cpu_done == 1'b0, 1, "no done after reset", 16'(cpu_done), 16'd0);
        snoop(2'd0, D, sh, fl);
        chk(sh == 1'b0 && fl == 1'b0, 1, "reset lines invalid", {14'd0, sh, fl}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VT[i];
            if (!v.kind[2]) begin
                cpu_run(v.kind[1:0], v.addr, v.shin, g0, g0a, g1, g1a, n);
                chk(n != 99, int'(v.rq), $sformatf("vec %0d completion", i), 16'(n), 16'd2);
                chk(g0 == v.e0, int'(v.rq), $sformatf("vec %0d first request", i), 16'(g0), 16'(v.e0));
                if (v.e0[2])
                    chk(g0a == v.e0a, int'(v.rq), $sformatf("vec %0d first address", i), 16'(g0a), 16'(v.e0a));
                chk(g1 == v.e1, int'(v.rq), $sformatf("vec %0d second request", i), 16'(g1), 16'(v.e1));
                if (v.e1[2])
                    chk(g1a == v.addr, int'(v.rq), $sformatf("vec %0d second address", i), 16'(g1a), 16'(v.addr));
            end else begin
                snoop(v.kind[1:0], v.addr, sh, fl);
                chk(sh == v.esh, int'(v.rq), $sformatf("vec %0d shared out", i), 16'(sh), 16'(v.esh));
                chk(fl == v.efl, int'(v.rq), $sformatf("vec %0d flush", i), 16'(fl), 16'(v.efl));
            end
        end

        // R10: pending upgrade loses its line to a read-exclusive snoop
        cpu_run(2'd0, D, 1'b1, g0, g0a, g1, g1a, n);
        chk(g0 == X_RD, 10, "setup fill of D", 16'(g0), 16'(X_RD));
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = D;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(bus_req_valid && bus_req_cmd == 2'd2, 10, "upgrade pending",
            {13'd0, bus_req_valid, bus_req_cmd}, 16'h6);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = D;
        #1;
        chk(snp_flush == 1'b0, 10, "shared line not flushed", 16'(snp_flush), 16'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req_valid && bus_req_cmd == 2'd1 && bus_req_addr == D, 10, "reissued as read-exclusive",
            {3'd0, bus_req_valid, bus_req_cmd, bus_req_addr[9:0]}, {3'd0, 1'b1, 2'd1, D[9:0]});
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk(cpu_done == 1'b1, 10, "write completes", 16'(cpu_done), 16'd1);
        cpu_run(2'd1, D, 1'b0, g0, g0a, g1, g1a, n);
        chk(g0 == X_NO, 10, "line now Modified", 16'(g0), 16'(X_NO));

        // R11: pending write-back cancelled by a read snoop of the victim
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = E;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(bus_req_valid && bus_req_cmd == 2'd3 && bus_req_addr == D, 11, "victim write-back pending",
            {3'd0, bus_req_valid, bus_req_cmd, bus_req_addr[9:0]}, {3'd0, 1'b1, 2'd3, D[9:0]});
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = D;
        #1;
        chk(snp_flush == 1'b1, 11, "victim flushed to snooper", 16'(snp_flush), 16'd1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req_valid == 1'b0, 11, "write-back withdrawn", 16'(bus_req_valid), 16'd0);
        @(negedge clk);
        chk(bus_req_valid && bus_req_cmd == 2'd0 && bus_req_addr == E, 11, "fill follows",
            {3'd0, bus_req_valid, bus_req_cmd, bus_req_addr[9:0]}, {3'd0, 1'b1, 2'd0, E[9:0]});
        bus_grant = 1'b1; bus_shared_in = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0; bus_shared_in = 1'b0;
        chk(cpu_done == 1'b1, 11, "miss completes", 16'(cpu_done), 16'd1);
        snoop(2'd0, D, sh, fl);
        chk(sh == 1'b0, 11, "victim replaced", 16'(sh), 16'd0);
        cpu_run(2'd1, E, 1'b0, g0, g0a, g1, g1a, n);
        chk(g0 == X_UPG, 3, "shared-line fill was Shared", 16'(g0), 16'(X_UPG));

        summary();
    end

endmodule